// File: doc/BRIEF.md
# Byte-addressable memory access unit

This block is a word-organized RAM placed behind a processor-style memory bus. A requester puts a byte address, write data and a transfer-size select on the bus, then raises either the read strobe or the write strobe. The unit takes a copy of the request and waits a fixed, parameterized number of cycles, which stands for the access time. It then commits the write or fetches the word, and raises a completion line. Completion stays high until the requester lets go of its strobe. The requester must then keep both strobes low for at least one cycle before the next operation. This models a cycle time that is longer than the access time.

Each word is 32 bits wide. The upper bits of the address pick the word and the lowest two bits pick a byte lane inside it. In full-word mode a transfer moves all 32 bits. In byte mode a write changes only the chosen lane. A byte read fetches the whole word but returns only the chosen byte, right-aligned. If both strobes are raised together, the unit ignores the request and pulses an error flag.

Top module: `byte_mem_unit`

## Requirements
- R1: The word index is address bits [MEM_AW+1:2]. Address bits above MEM_AW+1 are ignored, so addresses that differ only there reach the same word. Lane k is data bits [8k+7:8k], where k is address bits [1:0].
- R2: A full-word write (byte_mode=0) replaces all 32 bits of the addressed word with wdata.
- R3: A byte write (byte_mode=1) stores wdata[7:0] into the addressed lane only. The other three lanes of that word keep their previous contents.
- R4: done first goes high exactly LAT clock edges after the edge that accepts the request.
- R5: done stays high while rd_req or wr_req is held, and falls on the first edge that sees both low. A request is accepted only if both strobes were low on the previous edge.
- R6: If rd_req and wr_req are both high on an edge where a request could be accepted, the unit starts no operation and leaves memory unchanged. It raises err for exactly one cycle, and err does not repeat while the pair stays high.
- R7: A byte read returns the addressed lane in rdata[7:0], with rdata[31:8] zero, valid while done is high.
- R8: A full-word read returns the whole addressed word on rdata, valid while done is high.
- R9: After reset, done=0, err=0 and rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W (24) | Byte address: word index above, lane in [1:0] |
| wdata | input | 32 | Write data; lane data in [7:0] in byte mode |
| rd_req | input | 1 | Read strobe |
| wr_req | input | 1 | Write strobe |
| byte_mode | input | 1 | 1 = single-byte transfer, 0 = full word |
| rdata | output | 32 | Read result, held from completion on |
| done | output | 1 | Operation completed |
| err | output | 1 | One-cycle pulse on a read-and-write conflict |

## Verification
If the latency counter is off by even one, the completion edge moves to the wrong cycle. The bench sees this on the very next operation. A broken lane mask or byte steering shows up as a wrong byte in a neighbouring lane. That error is visible only when the word is read back, so every byte write in the sweep is followed by full-word reads of the words it touched. A handshake state that fails to return to idle shows at the ports in one of two ways: done stays high after the strobes drop, or a conflict fails to pulse err. The bench checks both within one or two cycles of the stimulus.

// File: rtl/mem_unit_pkg.sv
// Package: shared types and constants for the byte-addressable memory unit.
// Assumes 8-bit lanes; the word width must be a multiple of 8.
package mem_unit_pkg;
    localparam int LANE_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } mu_state_t;
endpackage

// File: rtl/mu_req_ctrl.sv
// Request controller: runs the bus handshake, counts the access latency,
// and flags read/write conflicts.
// Assumes the requester holds its strobe until done rises.
module mu_req_ctrl
    import mem_unit_pkg::*;
#(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic accept,
    output logic commit,
    output logic done,
    output logic err
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;

    mu_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic             gap_q;
    logic             one_req;
    logic             both_req;

    assign one_req  = rd_req ^ wr_req;
    assign both_req = rd_req & wr_req;
    assign accept   = (st == ST_IDLE) && gap_q && one_req;
    assign commit   = (st == ST_BUSY) && (cnt == '0);
    assign done     = (st == ST_DONE);

    // Purpose: state, latency count, idle-gap tracking and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= ST_IDLE;
            cnt   <= '0;
            gap_q <= 1'b1;
            err   <= 1'b0;
        end else begin
            gap_q <= !rd_req && !wr_req;
            err   <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (gap_q && one_req) begin
                        st  <= ST_BUSY;
                        cnt <= CNT_W'(LAT - 1);
                    end else if (gap_q && both_req) begin
                        err <= 1'b1;
                    end
                end
                ST_BUSY: begin
                    if (cnt == '0) st <= ST_DONE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_DONE: begin
                    if (!rd_req && !wr_req) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mu_lane_steer.sv
// Lane steering: builds the per-lane write enables and the write word, and
// aligns read data for byte or full-word transfers.
// Assumes lane 0 is the least significant byte.
module mu_lane_steer
    import mem_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / LANE_BITS,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              byte_mode,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] rword,
    output logic [LANES-1:0]  lane_en,
    output logic [DATA_W-1:0] wword,
    output logic [DATA_W-1:0] rsel
);
    logic [LANE_BITS-1:0] rd_lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Purpose: enable and write data for lane g.
        always_comb begin
            lane_en[g] = !byte_mode || (lane == LANE_W'(g));
            wword[g*LANE_BITS +: LANE_BITS] = byte_mode ? wdata[LANE_BITS-1:0]
                                                        : wdata[g*LANE_BITS +: LANE_BITS];
        end
        assign rd_lanes[g] = rword[g*LANE_BITS +: LANE_BITS];
    end

    // Purpose: choose the whole word or the selected byte, right-aligned.
    always_comb begin
        if (byte_mode) rsel = {{(DATA_W-LANE_BITS){1'b0}}, rd_lanes[lane]};
        else           rsel = rword;
    end
endmodule

// File: rtl/mu_word_store.sv
// Word storage: one byte-wide bank per lane, each with its own write enable,
// so a masked write cannot reach the other lanes. Reads are combinational.
// Assumes contents are undefined until written.
module mu_word_store
    import mem_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_AW = 6,
    parameter int LANES  = DATA_W / LANE_BITS
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we_lane,
    input  logic [MEM_AW-1:0] idx,
    input  logic [DATA_W-1:0] wword,
    output logic [DATA_W-1:0] rword
);
    localparam int DEPTH = 1 << MEM_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_BITS-1:0] bank [DEPTH];

        // Purpose: write lane g of the addressed word when enabled.
        always_ff @(posedge clk) begin
            if (we_lane[g]) bank[idx] <= wword[g*LANE_BITS +: LANE_BITS];
        end

        assign rword[g*LANE_BITS +: LANE_BITS] = bank[idx];
    end
endmodule

// File: rtl/byte_mem_unit.sv
// Byte-addressable memory access unit: word RAM with a read/write/completion
// handshake, a byte or full-word size select and lane-masked byte writes.
// Assumes ADDR_W >= MEM_AW + 2; address bits above the word index are ignored.
module byte_mem_unit
    import mem_unit_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int MEM_AW = 6,
    parameter int LAT    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic              byte_mode,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              err
);
    localparam int LANES  = DATA_W / LANE_BITS;
    localparam int LANE_W = $clog2(LANES);

    logic              accept;
    logic              commit;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic              lat_byte;
    logic              lat_rd;
    logic [LANES-1:0]  lane_en;
    logic [LANES-1:0]  we_lane;
    logic [DATA_W-1:0] wword;
    logic [DATA_W-1:0] rword;
    logic [DATA_W-1:0] rsel;

    mu_req_ctrl #(.LAT(LAT)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .wr_req (wr_req),
        .accept (accept),
        .commit (commit),
        .done   (done),
        .err    (err)
    );

    // Purpose: capture address, data, size and direction when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_byte <= 1'b0;
            lat_rd   <= 1'b0;
        end else if (accept) begin
            lat_addr <= addr;
            lat_data <= wdata;
            lat_byte <= byte_mode;
            lat_rd   <= rd_req;
        end
    end

    mu_lane_steer #(.DATA_W(DATA_W)) u_steer (
        .byte_mode (lat_byte),
        .lane      (lat_addr[LANE_W-1:0]),
        .wdata     (lat_data),
        .rword     (rword),
        .lane_en   (lane_en),
        .wword     (wword),
        .rsel      (rsel)
    );

    assign we_lane = (commit && !lat_rd) ? lane_en : '0;

    mu_word_store #(.DATA_W(DATA_W), .MEM_AW(MEM_AW)) u_store (
        .clk     (clk),
        .we_lane (we_lane),
        .idx     (lat_addr[LANE_W +: MEM_AW]),
        .wword   (wword),
        .rword   (rword)
    );

    // Purpose: load read data at completion and hold it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n)               rdata <= '0;
        else if (commit && lat_rd) rdata <= rsel;
    end
endmodule

// File: rtl/mu_checker.sv
// Checker for byte_mem_unit: handshake timing, lane masking and the error pulse.
// Bound to the top module; observes ports and the latched request attributes.
module mu_checker #(
    parameter int DATA_W = 32,
    parameter int LAT    = 3,
    parameter int LANES  = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic              wr_req,
    input logic              done,
    input logic              err,
    input logic [DATA_W-1:0] rdata,
    input logic              lat_rd,
    input logic              lat_byte,
    input logic [LANES-1:0]  we_lane
);
    logic [15:0] run;

    // Purpose: count edges with a single strobe held and no completion yet.
    always_ff @(posedge clk) begin
        if (!rst_n)                              run <= '0;
        else if ((rd_req ^ wr_req) && !done) begin
            if (run != 16'hFFFF) run <= run + 1'b1;
        end
        else if (!rd_req && !wr_req)             run <= '0;
    end

    // R4: the completion edge comes LAT edges after the accepting edge
    a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (run == 16'(LAT + 1)));

    // R5: completion holds while a strobe is held
    a_r5_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (rd_req || wr_req)) |=> done);

    // R5: completion falls once both strobes are low
    a_r5_done_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rd_req && !wr_req) |=> !done);

    // R6: the error flag lasts one cycle
    a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);

    // R6: a conflict neither completes nor writes
    a_r6_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!done && (we_lane == '0)));

    // R3: a byte write enables exactly one lane
    a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        ((|we_lane) && lat_byte) |-> ($countones(we_lane) == 1));

    // R2: a word write enables every lane
    a_r2_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        ((|we_lane) && !lat_byte) |-> (&we_lane));

    // R7: byte read data is zero above bit 7
    a_r7_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_rd && lat_byte) |-> (rdata[DATA_W-1:8] == '0));
endmodule

bind byte_mem_unit mu_checker #(.DATA_W(DATA_W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .wr_req   (wr_req),
    .done     (done),
    .err      (err),
    .rdata    (rdata),
    .lat_rd   (lat_rd),
    .lat_byte (lat_byte),
    .we_lane  (we_lane)
);

// File: tb/byte_mem_unit_tb.sv
`timescale 1ns/1ps
// Bench: sweeps word writes/reads, byte writes and reads on every lane,
// aliasing, the hold/drop handshake and conflicts, against a bench-side model.
module byte_mem_unit_tb;
    localparam int ADDR_W = 24;
    localparam int MEM_AW = 6;
    localparam int LAT    = 3;
    localparam int WORDS  = 1 << MEM_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic              rd_req = 1'b0;
    logic              wr_req = 1'b0;
    logic              byte_mode = 1'b0;
    logic [31:0]       rdata;
    logic              done;
    logic              err;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    logic [31:0] model [WORDS];

    always #2.5 clk = ~clk;

    byte_mem_unit #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .LAT(LAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .rd_req(rd_req), .wr_req(wr_req), .byte_mode(byte_mode),
        .rdata(rdata), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return {8'(i) ^ 8'h3C, ~8'(i), 8'(i) + 8'h11, 8'hC0 | 8'(i)};
    endfunction

    // One operation; checks latency (R4) and the drop of done (R5).
    task automatic run_op(input bit is_rd, input logic [ADDR_W-1:0] a,
                          input logic [31:0] d, input bit bm, input int hold,
                          output logic [31:0] q);
        int n;
        @(negedge clk);
        addr = a; wdata = d; byte_mode = bm; rd_req = is_rd; wr_req = !is_rd;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 40);
        chk(n == LAT + 1, "R4 latency", 32'(n), 32'(LAT + 1));
        q = rdata;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            chk(done == 1'b1, "R5 hold", 32'(done), 32'd1);
            chk(rdata == q, "R5 data held", rdata, q);
        end
        rd_req = 1'b0; wr_req = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R5 drop", 32'(done), 32'd0);
    endtask

    initial begin
        logic [31:0] q;
        logic [31:0] exp;
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R9 done", 32'(done), 32'd0);
        chk(err == 1'b0, "R9 err", 32'(err), 32'd0);
        chk(rdata == 32'd0, "R9 rdata", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && err == 1'b0, "R9 after release", {30'd0, done, err}, 32'd0);

        // R2: word write sweep
        for (int w = 0; w < WORDS; w++) begin
            run_op(1'b0, ADDR_W'(w * 4), pat(w), 1'b0, 0, q);
            model[w] = pat(w);
        end
        // R8: word read sweep
        for (int w = 0; w < WORDS; w++) begin
            run_op(1'b1, ADDR_W'(w * 4), 32'hDEAD_BEEF, 1'b0, 0, q);
            chk(q == model[w], "R8/R2 word read", q, model[w]);
        end
        // R3: byte write on every lane, verified by word reads
        for (int w = 0; w < 16; w++) begin
            for (int l = 0; l < 4; l++) begin
                logic [7:0] b;
                b = 8'h5A ^ 8'(w * 4 + l);
                run_op(1'b0, ADDR_W'(w * 4 + l), {24'hFFFFFF, b}, 1'b1, 0, q);
                model[w][l*8 +: 8] = b;
                run_op(1'b1, ADDR_W'(w * 4), 32'd0, 1'b0, 0, q);
                chk(q == model[w], "R3 byte write lane mask", q, model[w]);
            end
        end
        // R7 and R1: byte read of every lane of every word
        for (int w = 0; w < WORDS; w++) begin
            for (int l = 0; l < 4; l++) begin
                run_op(1'b1, ADDR_W'(w * 4 + l), 32'd0, 1'b1, 0, q);
                exp = {24'd0, model[w][l*8 +: 8]};
                chk(q == exp, "R7 byte read", q, exp);
            end
        end
        // R1: upper address bits ignored
        run_op(1'b0, ADDR_W'(24'hA50000 | (7 * 4)), 32'h1357_9BDF, 1'b0, 0, q);
        model[7] = 32'h1357_9BDF;
        run_op(1'b1, ADDR_W'(7 * 4), 32'd0, 1'b0, 0, q);
        chk(q == model[7], "R1 alias", q, model[7]);
        run_op(1'b1, ADDR_W'(24'h3F0000 | (7 * 4 + 2)), 32'd0, 1'b1, 0, q);
        chk(q == 32'h0000_0057, "R1 alias byte lane 2", q, 32'h0000_0057);
        // R5: done held while strobe stays high
        run_op(1'b1, ADDR_W'(7 * 4), 32'd0, 1'b0, 3, q);
        chk(q == model[7], "R5 held read", q, model[7]);

        // R6: conflict
        @(negedge clk);
        addr = ADDR_W'(5 * 4); wdata = 32'hFFFF_FFFF; byte_mode = 1'b0;
        rd_req = 1'b1; wr_req = 1'b1;
        @(negedge clk);
        chk(err == 1'b1, "R6 err raised", 32'(err), 32'd1);
        @(negedge clk);
        chk(err == 1'b0, "R6 err one cycle", 32'(err), 32'd0);
        // R5: dropping one strobe without a gap must not start an operation
        wr_req = 1'b0;
        for (int k = 0; k < LAT + 4; k++) begin
            @(negedge clk);
            chk(done == 1'b0 && err == 1'b0, "R5 no accept without gap",
                {30'd0, done, err}, 32'd0);
        end
        rd_req = 1'b0;
        @(negedge clk);
        run_op(1'b1, ADDR_W'(5 * 4), 32'd0, 1'b0, 0, q);
        chk(q == model[5], "R6 memory unchanged", q, model[5]);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1;
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule